// File: doc/BRIEF.md
# Per-Line Activation and Loopback Router

This block serves a single subscriber line of a multi-line 2B+D transceiver. It watches that line's 8-bit control byte, decides whether the line is powered up, and steers the two 8-bit bearer channels (B1, B2) and the 2-bit signalling channel (D) on each frame. Data can flow in the normal direction (digital side to line, line to digital side) or be turned back by one of several loopback paths.

The line-side outputs feed the line coder. The digital-side outputs feed the timeslot logic. The router updates its registered outputs one clock after a frame strobe. It holds them between strobes. While the line is down it forces every data output to zero and drops the line-output enable. Three loopback selects act on the line side: full, B1-only and B2-only. A fourth loopback returns digital data to the digital side. None of them has any effect unless the line is activated.

Top module: `lbr_line_router`

## Requirements
- R1: While reset is asserted, line_oe is 0, powered_down is 1, and every data output is 0.
- R2: Control bit 7 activates the line. On the clock after bit 7 is sampled high, line_oe is 1 and powered_down is 0. On the clock after bit 7 is sampled low, line_oe is 0 and powered_down is 1.
- R3: On every clock where bit 7 is sampled low, all six data outputs become 0. This holds whatever the other control bits and the frame strobe are.
- R4: With the line active and control bits 5, 4, 3 and 2 all 0, a frame strobe makes two things true on the next clock: each line output equals its digital input, and each digital output equals its line input. Control bits 6, 1 and 0 never change any output.
- R5: With the line active and bit 5 set, a strobe loops all three channels on the line side: each line output equals the matching line input. The digital outputs still carry the line inputs unchanged, unless R9 applies.
- R6: With the line active, bit 4 set and bit 5 clear, only B1 is looped on the line side. The line B2 and D outputs come from the digital inputs.
- R7: With the line active, bit 3 set and bit 5 clear, only B2 is looped on the line side. The line B1 and D outputs come from the digital inputs.
- R8: When bit 5 is set together with bit 4 or bit 3, the full loopback wins and D is also looped on the line side.
- R9: With the line active and bit 2 set, a strobe returns each digital input to the matching digital output. The line outputs follow R4 to R8 independently.
- R10: While the line stays active, no output changes on a clock where the frame strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctrl | input | 8 | Line control byte |
| frame_stb | input | 1 | Frame strobe, one clock wide |
| dig_b1_in | input | 8 | B1 from the digital side |
| dig_b2_in | input | 8 | B2 from the digital side |
| dig_d_in | input | 2 | D from the digital side |
| line_b1_rx | input | 8 | B1 received from the line |
| line_b2_rx | input | 8 | B2 received from the line |
| line_d_rx | input | 2 | D received from the line |
| line_b1_tx | output | 8 | B1 toward the line |
| line_b2_tx | output | 8 | B2 toward the line |
| line_d_tx | output | 2 | D toward the line |
| line_oe | output | 1 | Line-output enable |
| powered_down | output | 1 | Line is deactivated |
| dig_b1_out | output | 8 | B1 toward the digital side |
| dig_b2_out | output | 8 | B2 toward the digital side |
| dig_d_out | output | 2 | D toward the digital side |

## Verification
Several rules are checked on every clock by assertions. Outputs are zero while the line is down. The enable and the power-down flag are never equal. Outputs hold between strobes. The full line loopback and the digital loopback copy their sources on a strobe. The decoded D loopback implies both B loopbacks. The bench's scenarios are needed for the rest. These are the per-channel mixes of the B1-only and B2-only loopbacks, the independence of the digital loopback from the line-side paths, and the fact that bits 6, 1 and 0 change nothing. So is the way outputs stay zero after reactivation until the first strobe. These cases are covered by directed sequences and by seeded random control bytes and data.

// File: rtl/lbr_pkg.sv
package lbr_pkg;

   // Decoded routing decision for one line, already gated by activation
   typedef struct packed {
      logic active;
      logic lb_b1;
      logic lb_b2;
      logic lb_d;
      logic dig_lb;
   } lbr_route_t;

endpackage

// File: rtl/lbr_ctrl_decode.sv
module lbr_ctrl_decode
   import lbr_pkg::*;
#(
   parameter int CTRL_W      = 8,
   parameter int ACT_BIT     = 7,
   parameter int FULL_LB_BIT = 5,
   parameter int B1_LB_BIT   = 4,
   parameter int B2_LB_BIT   = 3,
   parameter int DIG_LB_BIT  = 2
) (
   input  logic [CTRL_W-1:0] ctrl,
   output lbr_route_t        route
);

   localparam int MAX_BIT = CTRL_W - 1;

   generate
      if (ACT_BIT > MAX_BIT || FULL_LB_BIT > MAX_BIT || B1_LB_BIT > MAX_BIT ||
          B2_LB_BIT > MAX_BIT || DIG_LB_BIT > MAX_BIT) begin : g_bad_pos
         $error("lbr_ctrl_decode: control bit position outside control width");
      end
      if (ACT_BIT == FULL_LB_BIT || ACT_BIT == B1_LB_BIT || ACT_BIT == B2_LB_BIT ||
          ACT_BIT == DIG_LB_BIT || FULL_LB_BIT == B1_LB_BIT ||
          FULL_LB_BIT == B2_LB_BIT || B1_LB_BIT == B2_LB_BIT) begin : g_overlap
         $error("lbr_ctrl_decode: control bit positions overlap");
      end
   endgenerate

   logic act;
   logic full_sel;

   always_comb begin
      act          = ctrl[ACT_BIT];
      full_sel     = ctrl[FULL_LB_BIT];
      route.active = act;
      // full loopback has priority and is the only way D loops to the line
      route.lb_b1  = act & (full_sel | ctrl[B1_LB_BIT]);
      route.lb_b2  = act & (full_sel | ctrl[B2_LB_BIT]);
      route.lb_d   = act & full_sel;
      route.dig_lb = act & ctrl[DIG_LB_BIT];
   end

   // R8: a looped D channel always comes with both bearer channels looped
   always_comb begin
      assert_full_priority_R8 : assert (!route.lb_d || (route.lb_b1 && route.lb_b2));
   end

endmodule

// File: rtl/lbr_power.sv
module lbr_power #(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic line_oe,
   output logic powered_down
);

   logic oe_q;
   logic pd_q;

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               oe_q <= 1'b0;
               pd_q <= 1'b1;
            end else begin
               oe_q <= active;
               pd_q <= !active;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               oe_q <= 1'b0;
               pd_q <= 1'b1;
            end else begin
               oe_q <= active;
               pd_q <= !active;
            end
         end
      end
   endgenerate

   assign line_oe      = oe_q;
   assign powered_down = pd_q;

   // R2: enable and power-down flag are always complementary
   assert_pd_complement_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      line_oe != powered_down);

   // R2: activation shows on the next clock
   assert_activate_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      active |=> (line_oe && !powered_down));

   assert_deactivate_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!line_oe && powered_down));

endmodule

// File: rtl/lbr_channel.sv
module lbr_channel #(
   parameter int W         = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act,
   input  logic         stb,
   input  logic         line_lb,
   input  logic         dig_lb,
   input  logic [W-1:0] dig_in,
   input  logic [W-1:0] line_rx,
   output logic [W-1:0] line_tx,
   output logic [W-1:0] dig_out
);

   localparam logic [W-1:0] ZERO = '0;

   generate
      if (W < 1) begin : g_bad_w
         $error("lbr_channel: channel width must be at least 1");
      end
   endgenerate

   logic [W-1:0] tx_q;
   logic [W-1:0] dout_q;
   logic [W-1:0] tx_nxt;
   logic [W-1:0] dout_nxt;

   always_comb begin
      tx_nxt   = tx_q;
      dout_nxt = dout_q;
      if (!act) begin
         tx_nxt   = ZERO;
         dout_nxt = ZERO;
      end else if (stb) begin
         tx_nxt   = line_lb ? line_rx : dig_in;
         dout_nxt = dig_lb  ? dig_in  : line_rx;
      end
   end

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_q   <= ZERO;
               dout_q <= ZERO;
            end else begin
               tx_q   <= tx_nxt;
               dout_q <= dout_nxt;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tx_q   <= ZERO;
               dout_q <= ZERO;
            end else begin
               tx_q   <= tx_nxt;
               dout_q <= dout_nxt;
            end
         end
      end
   endgenerate

   assign line_tx = tx_q;
   assign dig_out = dout_q;

   // R3: a deactivated line clears both directions on the next clock
   assert_deact_clear_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (line_tx == ZERO && dig_out == ZERO));

   // R10: no strobe while active means nothing moves
   assert_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (act && !stb) |=> ($stable(line_tx) && $stable(dig_out)));

   // R5: line loopback copies the received word to the line output
   assert_line_loop_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (act && stb && line_lb) |=> (line_tx == $past(line_rx)));

   // R9: digital loopback copies the digital input to the digital output
   assert_dig_loop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (act && stb && dig_lb) |=> (dig_out == $past(dig_in)));

endmodule

// File: rtl/lbr_line_router.sv
module lbr_line_router
   import lbr_pkg::*;
#(
   parameter int B_W         = 8,
   parameter int D_W         = 2,
   parameter int CTRL_W      = 8,
   parameter int ACT_BIT     = 7,
   parameter int FULL_LB_BIT = 5,
   parameter int B1_LB_BIT   = 4,
   parameter int B2_LB_BIT   = 3,
   parameter int DIG_LB_BIT  = 2,
   parameter bit ASYNC_RST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTRL_W-1:0] ctrl,
   input  logic              frame_stb,
   input  logic [B_W-1:0]    dig_b1_in,
   input  logic [B_W-1:0]    dig_b2_in,
   input  logic [D_W-1:0]    dig_d_in,
   input  logic [B_W-1:0]    line_b1_rx,
   input  logic [B_W-1:0]    line_b2_rx,
   input  logic [D_W-1:0]    line_d_rx,
   output logic [B_W-1:0]    line_b1_tx,
   output logic [B_W-1:0]    line_b2_tx,
   output logic [D_W-1:0]    line_d_tx,
   output logic              line_oe,
   output logic              powered_down,
   output logic [B_W-1:0]    dig_b1_out,
   output logic [B_W-1:0]    dig_b2_out,
   output logic [D_W-1:0]    dig_d_out
);

   generate
      if (B_W < 1 || D_W < 1) begin : g_bad_width
         $error("lbr_line_router: channel widths must be positive");
      end
   endgenerate

   lbr_route_t route;

   lbr_ctrl_decode #(
      .CTRL_W      (CTRL_W),
      .ACT_BIT     (ACT_BIT),
      .FULL_LB_BIT (FULL_LB_BIT),
      .B1_LB_BIT   (B1_LB_BIT),
      .B2_LB_BIT   (B2_LB_BIT),
      .DIG_LB_BIT  (DIG_LB_BIT)
   ) u_decode (
      .ctrl  (ctrl),
      .route (route)
   );

   lbr_power #(.ASYNC_RST(ASYNC_RST)) u_power (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (route.active),
      .line_oe      (line_oe),
      .powered_down (powered_down)
   );

   lbr_channel #(.W(B_W), .ASYNC_RST(ASYNC_RST)) u_b1 (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (route.active),
      .stb     (frame_stb),
      .line_lb (route.lb_b1),
      .dig_lb  (route.dig_lb),
      .dig_in  (dig_b1_in),
      .line_rx (line_b1_rx),
      .line_tx (line_b1_tx),
      .dig_out (dig_b1_out)
   );

   lbr_channel #(.W(B_W), .ASYNC_RST(ASYNC_RST)) u_b2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (route.active),
      .stb     (frame_stb),
      .line_lb (route.lb_b2),
      .dig_lb  (route.dig_lb),
      .dig_in  (dig_b2_in),
      .line_rx (line_b2_rx),
      .line_tx (line_b2_tx),
      .dig_out (dig_b2_out)
   );

   lbr_channel #(.W(D_W), .ASYNC_RST(ASYNC_RST)) u_d (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (route.active),
      .stb     (frame_stb),
      .line_lb (route.lb_d),
      .dig_lb  (route.dig_lb),
      .dig_in  (dig_d_in),
      .line_rx (line_d_rx),
      .line_tx (line_d_tx),
      .dig_out (dig_d_out)
   );

   // R3: with the enable low every data output is zero
   assert_idle_zero_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe |-> (line_b1_tx == '0 && line_b2_tx == '0 && line_d_tx == '0 &&
                    dig_b1_out == '0 && dig_b2_out == '0 && dig_d_out == '0));

endmodule

// File: tb/lbr_line_router_bench.sv
`timescale 1ns/1ps
module lbr_line_router_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] ctrl;
   logic       frame_stb;
   logic [7:0] dig_b1_in, dig_b2_in, line_b1_rx, line_b2_rx;
   logic [1:0] dig_d_in, line_d_rx;
   logic [7:0] line_b1_tx, line_b2_tx, dig_b1_out, dig_b2_out;
   logic [1:0] line_d_tx, dig_d_out;
   logic       line_oe, powered_down;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   logic [7:0] e_lb1, e_lb2, e_db1, e_db2;
   logic [1:0] e_ld, e_dd;
   logic       e_oe, e_pd;

   always #2.5 clk = ~clk;

   lbr_line_router u_lbr_line_router (
      .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .frame_stb(frame_stb),
      .dig_b1_in(dig_b1_in), .dig_b2_in(dig_b2_in), .dig_d_in(dig_d_in),
      .line_b1_rx(line_b1_rx), .line_b2_rx(line_b2_rx), .line_d_rx(line_d_rx),
      .line_b1_tx(line_b1_tx), .line_b2_tx(line_b2_tx), .line_d_tx(line_d_tx),
      .line_oe(line_oe), .powered_down(powered_down),
      .dig_b1_out(dig_b1_out), .dig_b2_out(dig_b2_out), .dig_d_out(dig_d_out)
   );

   task automatic chk(input string tag, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // requirement a strobed step exercises
   function automatic string tag_of(input logic [7:0] c, input logic s);
      if (!c[7])              return "R3";
      if (!s)                 return "R10";
      if (c[5] && (c[4] || c[3])) return "R8";
      if (c[5])               return "R5";
      if (c[4])               return "R6";
      if (c[3])               return "R7";
      if (c[2])               return "R9";
      return "R4";
   endfunction

   function automatic logic [7:0] pick(input logic sel, input logic [7:0] a,
                                       input logic [7:0] b);
      return sel ? a : b;
   endfunction

   task automatic step(input logic [7:0] c, input logic s,
                       input logic [7:0] db1, input logic [7:0] db2, input logic [1:0] dd,
                       input logic [7:0] rb1, input logic [7:0] rb2, input logic [1:0] rd);
      string t;
      @(negedge clk);
      ctrl = c; frame_stb = s;
      dig_b1_in = db1; dig_b2_in = db2; dig_d_in = dd;
      line_b1_rx = rb1; line_b2_rx = rb2; line_d_rx = rd;
      if (!c[7]) begin
         e_oe = 0; e_pd = 1;
         e_lb1 = 0; e_lb2 = 0; e_ld = 0; e_db1 = 0; e_db2 = 0; e_dd = 0;
      end else begin
         e_oe = 1; e_pd = 0;
         if (s) begin
            e_lb1 = pick(c[5] | c[4], rb1, db1);
            e_lb2 = pick(c[5] | c[3], rb2, db2);
            e_ld  = 2'(pick(c[5], {6'b0, rd}, {6'b0, dd}));
            e_db1 = pick(c[2], db1, rb1);
            e_db2 = pick(c[2], db2, rb2);
            e_dd  = 2'(pick(c[2], {6'b0, dd}, {6'b0, rd}));
         end
      end
      @(posedge clk);
      #1;
      t = tag_of(c, s);
      chk("R2", "line_oe", {7'b0, line_oe}, {7'b0, e_oe});
      chk("R2", "powered_down", {7'b0, powered_down}, {7'b0, e_pd});
      chk(t, "line_b1_tx", line_b1_tx, e_lb1);
      chk(t, "line_b2_tx", line_b2_tx, e_lb2);
      chk(t, "line_d_tx", {6'b0, line_d_tx}, {6'b0, e_ld});
      chk(t, "dig_b1_out", dig_b1_out, e_db1);
      chk(t, "dig_b2_out", dig_b2_out, e_db2);
      chk(t, "dig_d_out", {6'b0, dig_d_out}, {6'b0, e_dd});
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd20241);
      rst_n = 0; ctrl = 8'hFF; frame_stb = 1;
      dig_b1_in = 8'hA5; dig_b2_in = 8'h5A; dig_d_in = 2'b11;
      line_b1_rx = 8'h3C; line_b2_rx = 8'hC3; line_d_rx = 2'b10;
      e_lb1 = 0; e_lb2 = 0; e_ld = 0; e_db1 = 0; e_db2 = 0; e_dd = 0;
      e_oe = 0; e_pd = 1;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state even with all control bits and strobe high
      chk("R1", "line_oe", {7'b0, line_oe}, 8'h0);
      chk("R1", "powered_down", {7'b0, powered_down}, 8'h1);
      chk("R1", "line_b1_tx", line_b1_tx, 8'h0);
      chk("R1", "dig_b1_out", dig_b1_out, 8'h0);
      chk("R1", "line_d_tx", {6'b0, line_d_tx}, 8'h0);
      @(negedge clk);
      ctrl = 8'h00; frame_stb = 0;
      rst_n = 1;

      // R3: loopback bits while deactivated do nothing
      step(8'h3C, 1, 8'h11, 8'h22, 2'b01, 8'h33, 8'h44, 2'b10);
      // R2/R10: activation without strobe keeps zero data
      step(8'h80, 0, 8'h11, 8'h22, 2'b01, 8'h33, 8'h44, 2'b10);
      // R4: normal path, ignored bits 6,1,0 set
      step(8'hC3, 1, 8'h11, 8'h22, 2'b01, 8'h33, 8'h44, 2'b10);
      // R10: hold with changed inputs
      step(8'h80, 0, 8'hEE, 8'hDD, 2'b11, 8'hCC, 8'hBB, 2'b00);
      // R5: full line loopback
      step(8'hA0, 1, 8'h01, 8'h02, 2'b01, 8'hF1, 8'hF2, 2'b10);
      // R8: full loopback with bit 4 and bit 3
      step(8'hB8, 1, 8'h55, 8'h66, 2'b00, 8'h77, 8'h88, 2'b11);
      // R6: B1-only loopback
      step(8'h90, 1, 8'h12, 8'h34, 2'b01, 8'h56, 8'h78, 2'b10);
      // R7: B2-only loopback
      step(8'h88, 1, 8'h9A, 8'hBC, 2'b10, 8'hDE, 8'hF0, 2'b01);
      // R9: digital loopback alone
      step(8'h84, 1, 8'h13, 8'h57, 2'b11, 8'h9B, 8'hDF, 2'b00);
      // R9 with R5: both loopbacks at once
      step(8'hA4, 1, 8'h24, 8'h68, 2'b10, 8'hAC, 8'hE0, 2'b01);
      // R3: deactivate with loopbacks still set
      step(8'h3C, 1, 8'hFF, 8'hFF, 2'b11, 8'hFF, 8'hFF, 2'b11);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [7:0] c;
         c = 8'($urandom);
         c[7] = ($urandom % 5) != 0;
         step(c, 1'($urandom % 2), 8'($urandom), 8'($urandom), 2'($urandom),
              8'($urandom), 8'($urandom), 2'($urandom));
      end
      finish_run();
   end

endmodule